// File: doc/BRIEF.md
# Timer Interrupt and Wakeup Controller

This block collects the three event strobes of a general purpose timer (input capture, counter overflow and compare match) and turns them into a level interrupt and a wakeup pulse. Each event passes through two separate masks. The interrupt-enable mask decides whether the event is latched into a sticky status register, and the interrupt line is high while any status bit is set. The wakeup-enable mask decides whether the event produces a one-cycle wakeup pulse. The two masks do not depend on each other, so an event can wake the system without being latched for the interrupt handler.

Software reaches the three registers through a plain register port: a write strobe with address and data, and a read strobe whose data returns one cycle later with a valid flag. There is no back-pressure on this port. A read or write is accepted in the cycle its strobe is high, and the read result is valid for exactly one cycle. Software clears status bits by writing ones to them. A write that sets the capture bit also sends a one-cycle rearm pulse to the capture unit, so the capture sequence starts again from its first capture.

Top module: `tiw_ctrl`

## Requirements
- R1: After reset the status register, both masks, `irq`, `wake` and `capt_rearm` are all zero, and every register reads back as zero.
- R2: A write to offset 0x1C (interrupt enable) or 0x20 (wakeup enable) keeps only data bits 2:0. Reading the same offset returns those bits with bits 31:3 zero.
- R3: The status bits are placed as follows: bit 2 is capture, bit 1 is overflow and bit 0 is match. On the clock edge that samples an event strobe, the matching status bit is set if its interrupt-enable bit is 1. If its enable bit is 0, the status bit keeps its value. Several events in one cycle set all of their enabled bits.
- R4: `irq` is a registered output equal to the OR of the status bits. It rises on the same edge that sets the first status bit.
- R5: A write to offset 0x18 (status) clears each status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. `irq` falls on the edge where the last set bit is cleared.
- R6: If an enabled event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R7: An event whose wakeup-enable bit is 1 makes `wake` high for the one cycle after the strobe, whatever the interrupt-enable mask holds. Without such an event, `wake` is low.
- R8: A status write with data bit 2 set makes `capt_rearm` high for one cycle, whether or not capture status was set. A status write with bit 2 clear gives no pulse.
- R9: A read strobe gives `rd_valid` high on the next cycle, with `rdata` holding the register addressed. Unmapped offsets read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_capture | input | 1 | Capture event strobe |
| ev_overflow | input | 1 | Overflow event strobe |
| ev_match | input | 1 | Compare match event strobe |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Register byte offset |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Read result valid, one cycle after rd |
| irq | output | 1 | Level interrupt, OR of the status bits |
| wake | output | 1 | One-cycle wakeup pulse |
| capt_rearm | output | 1 | One-cycle rearm pulse to the capture unit |

## Verification
Events are driven one at a time under masks that separate the interrupt path from the wakeup path. This shows whether each bit goes to the correct status position, and whether a masked event still wakes or still latches. All three events are also driven in the same cycle, to check that the status bits combine correctly. Clearing writes are tried with mixed one and zero patterns, with an all-zero pattern, and in the same cycle as an event on the same bit. These cases separate a true write-one-to-clear from a plain overwrite, and show which side wins the race. Writes to mask offsets with high bits set, and writes and reads at an unmapped offset, show whether the masks are truncated and whether decoding is exact.

// File: rtl/tiw_pkg.sv
`timescale 1ns/1ps
package tiw_pkg;
  localparam int EV_W      = 3;
  localparam int IDX_MATCH = 0;
  localparam int IDX_OVF   = 1;
  localparam int IDX_CAPT  = 2;
  typedef logic [EV_W-1:0] ev_vec_t;
endpackage

// File: rtl/tiw_mask_reg.sv
`timescale 1ns/1ps
module tiw_mask_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  tiw_pkg::ev_vec_t      wbits,
  output tiw_pkg::ev_vec_t      mask
);
  logic hit;
  assign hit = wr && (addr == OFFSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else if (hit) mask <= wbits;
  end

  // R2: a decoded write loads the low bits; anything else leaves the mask alone
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (mask == $past(wbits)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(mask));
endmodule

// File: rtl/tiw_status.sv
`timescale 1ns/1ps
module tiw_status
  import tiw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t ev,
  input  ev_vec_t ien,
  input  logic    clr_req,
  input  ev_vec_t clr_bits,
  output ev_vec_t status,
  output logic    irq,
  output logic    capt_rearm
);
  ev_vec_t set_v, kill_v, status_n;

  assign set_v  = ev & ien;
  assign kill_v = clr_req ? clr_bits : '0;

  // an event on a bit beats a clear of the same bit
  always_comb begin
    for (int i = 0; i < EV_W; i++)
      status_n[i] = set_v[i] | (status[i] & ~kill_v[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status     <= '0;
      irq        <= 1'b0;
      capt_rearm <= 1'b0;
    end else begin
      status     <= status_n;
      irq        <= |status_n;
      capt_rearm <= clr_req & clr_bits[IDX_CAPT];
    end
  end

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((status & $past(set_v)) == $past(set_v)));
  p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && ((ev & ~ien) != '0)) |=> ((status & ~$past(ien)) == ($past(status) & ~$past(ien))));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && ((set_v & clr_bits) == '0)) |=> ((status & $past(clr_bits)) == '0));
  p_race_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && ((set_v & clr_bits) != '0)) |=> ((status & $past(set_v & clr_bits)) != '0));
  p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && clr_bits[IDX_CAPT]) |=> capt_rearm);
  p_rearm_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capt_rearm |=> (!capt_rearm || $past(clr_req && clr_bits[IDX_CAPT])));
endmodule

// File: rtl/tiw_wake.sv
`timescale 1ns/1ps
module tiw_wake
  import tiw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t ev,
  input  ev_vec_t wen,
  output logic    wake
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= |(ev & wen);
  end

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev & wen)) |=> wake);
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev & wen) == '0) |=> !wake);
endmodule

// File: rtl/tiw_ctrl.sv
`timescale 1ns/1ps
module tiw_ctrl
  import tiw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFF_STAT = 'h18,
  parameter logic [ADDR_W-1:0] OFF_IEN  = 'h1C,
  parameter logic [ADDR_W-1:0] OFF_WEN  = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_capture,
  input  logic              ev_overflow,
  input  logic              ev_match,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              irq,
  output logic              wake,
  output logic              capt_rearm
);
  localparam int PAD_W = DATA_W - EV_W;

  ev_vec_t ev, ien, wen, status, wbits;
  logic    clr_req;
  logic    unused_hi;

  assign ev[IDX_CAPT]  = ev_capture;
  assign ev[IDX_OVF]   = ev_overflow;
  assign ev[IDX_MATCH] = ev_match;
  assign wbits     = wdata[EV_W-1:0];
  assign unused_hi = ^wdata[DATA_W-1:EV_W];
  assign clr_req   = wr && (addr == OFF_STAT);

  tiw_mask_reg #(.ADDR_W(ADDR_W), .OFFSET(OFF_IEN)) u_ien (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wbits(wbits), .mask(ien));

  tiw_mask_reg #(.ADDR_W(ADDR_W), .OFFSET(OFF_WEN)) u_wen (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wbits(wbits), .mask(wen));

  tiw_status u_stat (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ien(ien),
    .clr_req(clr_req), .clr_bits(wbits),
    .status(status), .irq(irq), .capt_rearm(capt_rearm));

  tiw_wake u_wake (
    .clk(clk), .rst_n(rst_n), .ev(ev), .wen(wen), .wake(wake));

  ev_vec_t rsel;
  always_comb begin
    rsel = '0;
    if (addr == OFF_STAT)     rsel = status;
    else if (addr == OFF_IEN) rsel = ien;
    else if (addr == OFF_WEN) rsel = wen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd;
      rdata    <= rd ? {{PAD_W{1'b0}}, rsel} : '0;
    end
  end

  p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|status));
  p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev & ien)) |=> irq);
  p_rdv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
  p_rdpad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rdata[DATA_W-1:EV_W] == '0));
endmodule

// File: tb/tiw_ctrl_test.sv
`timescale 1ns/1ps
module tiw_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_capture = 1'b0, ev_overflow = 1'b0, ev_match = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid, irq, wake, capt_rearm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  tiw_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ev_capture(ev_capture), .ev_overflow(ev_overflow),
    .ev_match(ev_match), .wr(wr), .rd(rd), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid), .irq(irq), .wake(wake), .capt_rearm(capt_rearm));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // one driven cycle: {capture,overflow,match} strobes plus optional write
  task automatic step(input logic [2:0] e, input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    {ev_capture, ev_overflow, ev_match} = e;
    wr = w; addr = a; wdata = d;
    @(negedge clk);
    {ev_capture, ev_overflow, ev_match} = 3'b000;
    wr = 1'b0; wdata = '0;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    step(3'b000, 1'b1, a, d);
  endtask

  task automatic rreg(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_t x;
    x.val = exp; x.tag = tag;
    @(negedge clk);
    rd = 1'b1; addr = a;
    sb.push_back(x);
    @(negedge clk);
    rd = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever a read result appears
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 unexpected rd_valid: actual %h expected none", rdata);
      end else begin
        exp_t x;
        x = sb.pop_front();
        chk(x.tag, rdata, x.val);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 wake", {31'b0, wake}, 32'd0);
    chk("R1 rearm", {31'b0, capt_rearm}, 32'd0);
    rreg(8'h18, 32'd0, "R1 status");
    rreg(8'h1C, 32'd0, "R1 ien");
    rreg(8'h20, 32'd0, "R1 wen");

    // R2: only low three bits kept
    wreg(8'h1C, 32'hFFFF_FFFA);
    rreg(8'h1C, 32'd2, "R2 ien trunc");
    wreg(8'h20, 32'h0000_00FD);
    rreg(8'h20, 32'd5, "R2 wen trunc");

    // R3/R4: overflow (bit1) enabled for irq, not for wake
    step(3'b010, 1'b0, 8'h00, 32'd0);
    chk("R4 irq rises", {31'b0, irq}, 32'd1);
    chk("R7 no wake ovf", {31'b0, wake}, 32'd0);
    rreg(8'h18, 32'd2, "R3 ovf bit1");

    // match (bit0): wake only, status unchanged
    step(3'b001, 1'b0, 8'h00, 32'd0);
    chk("R7 wake match", {31'b0, wake}, 32'd1);
    @(negedge clk);
    chk("R7 wake one cycle", {31'b0, wake}, 32'd0);
    rreg(8'h18, 32'd2, "R3 masked match");

    // capture (bit2) masked for irq, wakes
    step(3'b100, 1'b0, 8'h00, 32'd0);
    chk("R7 wake capture", {31'b0, wake}, 32'd1);
    rreg(8'h18, 32'd2, "R3 masked capture");
    wreg(8'h1C, 32'd7);
    step(3'b100, 1'b0, 8'h00, 32'd0);
    rreg(8'h18, 32'd6, "R3 capture bit2");

    // R5: write-one-to-clear
    wreg(8'h18, 32'd2);
    chk("R8 no rearm", {31'b0, capt_rearm}, 32'd0);
    chk("R5 irq held", {31'b0, irq}, 32'd1);
    rreg(8'h18, 32'd4, "R5 partial clear");
    wreg(8'h18, 32'd0);
    rreg(8'h18, 32'd4, "R5 zero write");
    wreg(8'h18, 32'd4);
    chk("R8 rearm", {31'b0, capt_rearm}, 32'd1);
    chk("R5 irq falls", {31'b0, irq}, 32'd0);
    @(negedge clk);
    chk("R8 rearm one cycle", {31'b0, capt_rearm}, 32'd0);
    rreg(8'h18, 32'd0, "R5 all clear");

    // R6: event beats clear
    step(3'b010, 1'b1, 8'h18, 32'd2);
    chk("R6 irq", {31'b0, irq}, 32'd1);
    rreg(8'h18, 32'd2, "R6 ovf race");
    step(3'b001, 1'b1, 8'h18, 32'd7);
    rreg(8'h18, 32'd1, "R6 match race");
    wreg(8'h18, 32'd1);
    rreg(8'h18, 32'd0, "R5 clear match");

    // R3: all events together
    step(3'b111, 1'b0, 8'h00, 32'd0);
    rreg(8'h18, 32'd7, "R3 all events");
    wreg(8'h18, 32'hFFFF_FFFF);
    chk("R5 irq after full clear", {31'b0, irq}, 32'd0);

    // R8: rearm even when capture status was clear
    wreg(8'h18, 32'd4);
    chk("R8 rearm idle", {31'b0, capt_rearm}, 32'd1);

    // R9: unmapped offset
    wreg(8'h24, 32'd0);
    rreg(8'h24, 32'd0, "R9 unmapped read");
    rreg(8'h1C, 32'd7, "R9 ien untouched");
    rreg(8'h20, 32'd5, "R9 wen untouched");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 missing reads: actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule